// File: doc/BRIEF.md
# Byte-Parity Guarded RAM with Reset Request

This block is a synchronous single-port RAM that keeps one parity bit next to every stored byte. A word of `LANES` bytes therefore carries `LANES` parity bits. Parity is even: the stored bit is the XOR of the eight data bits. It is computed and written along with the data, lane by lane, under the byte enables. A read returns the stored word one cycle after the request. In the cycle the word is returned, the block recomputes parity for the byte lanes enabled in the read and compares it with the stored bits.

A small register port exposes two 8-bit registers. The control register holds a reset-disable bit and a sticky parity-error flag. The cause register holds a flag that records that a parity-triggered reset request was issued. A mismatch always sets the error flag. When the disable bit is clear, the mismatch also drives a one-cycle reset request towards the system reset controller. Clearing the disable bit while an error is already flagged fires the request at once.

The design has two reset inputs. `rstN` is asserted by the reset controller for every reset, including a parity-triggered one. `causeRstN` is asserted for every other source. The cause flag is held only by `causeRstN`, so it survives the reset it caused. A test input flips stored parity bits on a write, so that errors can be forced.

Top module: `parity_ram_guard`

## Requirements
- R1: A write stores the data and a freshly computed parity bit only in the byte lanes whose `memByteEn` bit is 1. A read request returns the whole stored word on `memRdata` after the next rising edge. If `memWe` and `memRe` are both high, only the write takes place.
- R2: Parity is checked only on the byte lanes enabled in the read. A 1 in bit i of `memInjFlip` during a write stores the inverted parity for lane i, which forces a later mismatch on that lane.
- R3: Register select 0 is the control register: bit 7 is the reset-disable bit, bit 0 is the error flag, and bits 6 to 1 read as 0. Select 1 is the cause register: bit 0 is the cause flag, and bits 7 to 1 read as 0.
- R4: After `rstN`, the control register reads 0x00, provided the cause flag is clear, and `rstReq` is low.
- R5: With the disable bit at 0, a parity mismatch drives `rstReq` high for exactly one cycle. This is the cycle after the one in which the read data is returned.
- R6: A mismatch sets the error flag whatever the value of the disable bit. With the disable bit at 1, no request is issued.
- R7: A control write that changes the disable bit from 1 to 0 while the error flag is 1 drives `rstReq` high in the cycle after the write. The same write with the disable bit already 0 issues no request.
- R8: The cause flag is set in the cycle after any `rstReq` pulse. It is cleared by writing 0 to bit 0 of the cause register, or by `causeRstN`. Writing 1 to it and asserting `rstN` have no effect on it.
- R9: While the cause flag is 1, the error flag is held at 1, including after `rstN`, one cycle after release. When the cause flag is 0, writing 0 to control bit 0 clears the error flag. Writing 1 to control bit 0 never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset from any source; clears control state |
| causeRstN | input | 1 | Active-low reset from sources other than parity; clears the cause flag |
| memAddr | input | ADDR_W | Word address |
| memWdata | input | 8*LANES | Write data |
| memByteEn | input | LANES | Byte-lane enables for write and read check |
| memWe | input | 1 | Write request |
| memRe | input | 1 | Read request |
| memInjFlip | input | LANES | Test hook: invert stored parity of lane i on write |
| memRdata | output | 8*LANES | Read data, valid the cycle after a read request |
| regSel | input | 1 | Register select: 0 control, 1 cause |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for the selected register |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The bench forces mismatches through the flip input. It then reads with byte enables that include or exclude the corrupted lane, and repairs a lane by rewriting it. A design that checked every lane would raise false requests, and one that ignored the enables on write would corrupt neighbouring bytes. Directed tests cover the cases that are easy to get wrong: clearing the disable bit while the flag is pending must fire a request, but only on a 1-to-0 transition. The error flag must stay stuck while the cause flag is set. The cause flag must survive `rstN` and yield only to `causeRstN` or a written 0. The request is sampled in its single exact cycle, so an extra pipeline stage or a stretched pulse shows up as a wrong value.

// File: rtl/prg_pkg.sv
package prg_pkg;
  // Strobes issued by the control to the datapath.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } memCmd_t;

  // Event returned by the datapath to the control.
  typedef struct packed {
    logic errStb;
  } dpStat_t;

  localparam int unsigned CTL_DIS_BIT  = 7;
  localparam int unsigned CTL_FLAG_BIT = 0;
endpackage

// File: rtl/prg_lane_parity.sv
module prg_lane_parity #(
  parameter int unsigned LANES = 4,
  localparam int unsigned DATA_W = 8 * LANES
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [LANES-1:0]  parOut
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign parOut[g] = ^dataIn[g*8 +: 8];
  end
endmodule

// File: rtl/prg_datapath.sv
module prg_datapath
  import prg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = 8 * LANES,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  memCmd_t           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  byteEn,
  input  logic [LANES-1:0]  injFlip,
  output logic [DATA_W-1:0] rdata,
  output dpStat_t           stat
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [LANES-1:0]  parMem  [DEPTH];

  logic [LANES-1:0]  genPar;
  logic [LANES-1:0]  chkPar;
  logic [DATA_W-1:0] rdData;
  logic [LANES-1:0]  rdPar;
  logic [LANES-1:0]  rdMask;
  logic              rdValid;

  prg_lane_parity #(.LANES(LANES)) u_genPar (.dataIn(wdata),  .parOut(genPar));
  prg_lane_parity #(.LANES(LANES)) u_chkPar (.dataIn(rdData), .parOut(chkPar));

  // Per-lane storage update under the byte enables.
  for (genvar g = 0; g < LANES; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (cmd.wrStb && byteEn[g]) begin
        dataMem[addr][g*8 +: 8] <= wdata[g*8 +: 8];
        parMem[addr][g]         <= genPar[g] ^ injFlip[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.rdStb) begin
      rdData <= dataMem[addr];
      rdPar  <= parMem[addr];
      rdMask <= byteEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= cmd.rdStb;
  end

  assign rdata       = rdData;
  assign stat.errStb = rdValid && |((chkPar ^ rdPar) & rdMask);
endmodule

// File: rtl/prg_ctrl.sv
module prg_ctrl
  import prg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       causeRstN,
  input  logic       memWe,
  input  logic       memRe,
  input  logic       regSel,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  input  dpStat_t    stat,
  output memCmd_t    cmd,
  output logic [7:0] regRdata,
  output logic       rstReq,
  output logic       disableBit,
  output logic       statusBit,
  output logic       causeFlag
);
  logic ctlWr;
  logic causeWr;
  logic maskDrop;
  logic flagClr;

  // Write has priority over read in the same cycle.
  assign cmd.wrStb = memWe;
  assign cmd.rdStb = memRe && !memWe;

  assign ctlWr    = regWe && !regSel;
  assign causeWr  = regWe && regSel;
  assign maskDrop = ctlWr && disableBit && !regWdata[CTL_DIS_BIT] && statusBit;
  assign flagClr  = ctlWr && !regWdata[CTL_FLAG_BIT] && !causeFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disableBit <= 1'b0;
      statusBit  <= 1'b0;
      rstReq     <= 1'b0;
    end else begin
      if (ctlWr) disableBit <= regWdata[CTL_DIS_BIT];
      statusBit <= stat.errStb || causeFlag || (statusBit && !flagClr);
      rstReq    <= (stat.errStb && !disableBit) || maskDrop;
    end
  end

  always_ff @(posedge clk or negedge causeRstN) begin
    if (!causeRstN)                     causeFlag <= 1'b0;
    else if (rstReq)                    causeFlag <= 1'b1;
    else if (causeWr && !regWdata[0])   causeFlag <= 1'b0;
  end

  always_comb begin
    regRdata = 8'h00;
    if (regSel) begin
      regRdata[0] = causeFlag;
    end else begin
      regRdata[CTL_DIS_BIT]  = disableBit;
      regRdata[CTL_FLAG_BIT] = statusBit;
    end
  end
endmodule

// File: rtl/parity_ram_guard.sv
module parity_ram_guard
  import prg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              causeRstN,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  input  logic [LANES-1:0]  memByteEn,
  input  logic              memWe,
  input  logic              memRe,
  input  logic [LANES-1:0]  memInjFlip,
  output logic [DATA_W-1:0] memRdata,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              rstReq
);
  memCmd_t cmd;
  dpStat_t stat;
  logic    parErr;
  logic    disableBit;
  logic    statusBit;
  logic    causeFlag;

  assign parErr = stat.errStb;

  prg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .causeRstN(causeRstN),
    .memWe(memWe), .memRe(memRe),
    .regSel(regSel), .regWe(regWe), .regWdata(regWdata),
    .stat(stat), .cmd(cmd), .regRdata(regRdata), .rstReq(rstReq),
    .disableBit(disableBit), .statusBit(statusBit), .causeFlag(causeFlag)
  );

  prg_datapath #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(memAddr),
    .wdata(memWdata), .byteEn(memByteEn), .injFlip(memInjFlip),
    .rdata(memRdata), .stat(stat)
  );
endmodule

// File: rtl/prg_checker.sv
module prg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       causeRstN,
  input logic       regSel,
  input logic       regWe,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       rstReq,
  input logic       parErr,
  input logic       disableBit,
  input logic       statusBit,
  input logic       causeFlag
);
  p_err_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    parErr |=> statusBit);

  p_unmasked_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && !disableBit) |=> rstReq);

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && disableBit && !regWe) |=> !rstReq);

  p_req_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> ($past(parErr) ||
                $past(regWe && !regSel && disableBit && !regWdata[7])));

  p_cause_after_req_r8: assert property (@(posedge clk) disable iff (!rstN || !causeRstN)
    rstReq |=> causeFlag);

  p_flag_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    causeFlag |=> statusBit);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (regRdata[6:1] == 6'd0));
endmodule

bind parity_ram_guard prg_checker u_chk (
  .clk(clk), .rstN(rstN), .causeRstN(causeRstN),
  .regSel(regSel), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
  .rstReq(rstReq), .parErr(parErr), .disableBit(disableBit),
  .statusBit(statusBit), .causeFlag(causeFlag)
);

// File: tb/parity_ram_guard_tb.sv
module parity_ram_guard_tb;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 8 * LANES;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned NVEC   = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              causeRstN = 1'b0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [DATA_W-1:0] memWdata = '0;
  logic [LANES-1:0]  memByteEn = '0;
  logic              memWe = 1'b0;
  logic              memRe = 1'b0;
  logic [LANES-1:0]  memInjFlip = '0;
  logic [DATA_W-1:0] memRdata;
  logic              regSel = 1'b0;
  logic              regWe = 1'b0;
  logic [7:0]        regWdata = '0;
  logic [7:0]        regRdata;
  logic              rstReq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  parity_ram_guard #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dut (
    .clk(clk), .rstN(rstN), .causeRstN(causeRstN),
    .memAddr(memAddr), .memWdata(memWdata), .memByteEn(memByteEn),
    .memWe(memWe), .memRe(memRe), .memInjFlip(memInjFlip),
    .memRdata(memRdata), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .rstReq(rstReq)
  );

  // Vector: {wr, addr[5:0], data[31:0], be[3:0], inj[3:0], expData[31:0], expReq}
  localparam logic [79:0] VEC [NVEC] = '{
    {1'b1, 6'd5, 32'h11223344, 4'hF, 4'h0, 32'h0,        1'b0},
    {1'b0, 6'd5, 32'h0,        4'hF, 4'h0, 32'h11223344, 1'b0},
    {1'b1, 6'd6, 32'hA5A5A5A5, 4'hF, 4'h1, 32'h0,        1'b0},
    {1'b0, 6'd6, 32'h0,        4'hF, 4'h0, 32'hA5A5A5A5, 1'b1},
    {1'b0, 6'd6, 32'h0,        4'hE, 4'h0, 32'hA5A5A5A5, 1'b0},
    {1'b1, 6'd6, 32'h000000FF, 4'h1, 4'h0, 32'h0,        1'b0},
    {1'b0, 6'd6, 32'h0,        4'hF, 4'h0, 32'hA5A5A5FF, 1'b0},
    {1'b1, 6'd7, 32'hDEADBEEF, 4'hC, 4'h4, 32'h0,        1'b0},
    {1'b0, 6'd7, 32'h0,        4'h3, 4'h0, 32'hDEAD0000, 1'b0},
    {1'b0, 6'd7, 32'h0,        4'h4, 4'h0, 32'hDEAD0000, 1'b1},
    {1'b0, 6'd7, 32'h0,        4'h8, 4'h0, 32'hDEAD0000, 1'b0},
    {1'b0, 6'd5, 32'h0,        4'hF, 4'h0, 32'h11223344, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; regWdata = val; regWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [7:0] val);
    regSel = sel;
    #1;
    val = regRdata;
  endtask

  task automatic memWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic [LANES-1:0] be, input logic [LANES-1:0] inj);
    @(negedge clk);
    memAddr = a; memWdata = d; memByteEn = be; memInjFlip = inj; memWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    memWe = 1'b0; memInjFlip = '0;
  endtask

  task automatic memRead(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
                         output logic [DATA_W-1:0] d, output logic req);
    @(negedge clk);
    memAddr = a; memByteEn = be; memRe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = memRdata;
    memRe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req = rstReq;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]        rv;
    logic [DATA_W-1:0] rd;
    logic              rq;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1; causeRstN = 1'b1;

    // R4: reset state
    regRead(1'b0, rv); chk("R4 control after reset", {24'd0, rv}, 32'h00);
    regRead(1'b1, rv); chk("R8 cause after reset", {24'd0, rv}, 32'h00);
    chk("R4 rstReq after reset", {31'd0, rstReq}, 32'd0);

    // Initialise every location before any checked read.
    for (int i = 0; i < DEPTH; i++) memWrite(ADDR_W'(i), '0, '1, '0);

    // R1, R2, R5: vector table with disable bit 0
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][79]) begin
        memWrite(VEC[i][78:73], VEC[i][72:41], VEC[i][40:37], VEC[i][36:33]);
      end else begin
        memRead(VEC[i][78:73], VEC[i][40:37], rd, rq);
        chk($sformatf("R1 read data vec %0d", i), rd, VEC[i][32:1]);
        chk($sformatf("R5 R2 request vec %0d", i), {31'd0, rq}, {31'd0, VEC[i][0]});
      end
    end

    // R8: requests left the cause flag set; R6 flag set
    regRead(1'b1, rv); chk("R8 cause set by request", {24'd0, rv}, 32'h01);
    regRead(1'b0, rv); chk("R6 flag set by mismatch", {24'd0, rv}, 32'h01);

    // R9: flag cannot be cleared while cause is set
    regWrite(1'b0, 8'h00);
    regRead(1'b0, rv); chk("R9 flag held by cause", {24'd0, rv}, 32'h01);

    // R8: write 0 clears cause; R9 flag then clears on write 0
    regWrite(1'b1, 8'h00);
    regRead(1'b1, rv); chk("R8 cause cleared by write 0", {24'd0, rv}, 32'h00);
    regRead(1'b0, rv); chk("R9 flag retained after cause clear", {24'd0, rv}, 32'h01);
    regWrite(1'b0, 8'h00);
    regRead(1'b0, rv); chk("R9 flag cleared by write 0", {24'd0, rv}, 32'h00);

    // R3, R9: reserved bits read 0, writing 1 to flag does not set it
    regWrite(1'b0, 8'hFF);
    regRead(1'b0, rv); chk("R3 R9 control after write 0xFF", {24'd0, rv}, 32'h80);
    regWrite(1'b1, 8'hFF);
    regRead(1'b1, rv); chk("R3 R8 cause after write 0xFF", {24'd0, rv}, 32'h00);

    // R6: masked mismatch sets flag without request
    memWrite(6'd9, 32'h0F0F0F0F, 4'hF, 4'h2);
    memRead(6'd9, 4'hF, rd, rq);
    chk("R6 no request when disabled", {31'd0, rq}, 32'd0);
    regRead(1'b0, rv); chk("R6 flag set while disabled", {24'd0, rv}, 32'h81);

    // R7: dropping the disable bit with a pending flag fires a request
    regWrite(1'b0, 8'h00);
    chk("R7 request after mask drop", {31'd0, rstReq}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R5 R7 request lasts one cycle", {31'd0, rstReq}, 32'd0);
    regRead(1'b1, rv); chk("R8 cause set after mask drop", {24'd0, rv}, 32'h01);

    // R8, R9, R4: system reset keeps cause, flag re-held one cycle later
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R4 rstReq low after rstN", {31'd0, rstReq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    regRead(1'b0, rv); chk("R9 R4 control after rstN with cause", {24'd0, rv}, 32'h01);
    regRead(1'b1, rv); chk("R8 cause survives rstN", {24'd0, rv}, 32'h01);

    // R8: cause reset clears the flag
    causeRstN = 1'b0;
    @(negedge clk);
    causeRstN = 1'b1;
    regRead(1'b1, rv); chk("R8 cause cleared by causeRstN", {24'd0, rv}, 32'h00);

    // R7: write 0 to disable when already 0 issues no request
    regWrite(1'b0, 8'h00);
    chk("R7 no request without 1-to-0 change", {31'd0, rstReq}, 32'd0);

    // R1: write and read together performs only the write
    @(negedge clk);
    memAddr = 6'd12; memWdata = 32'hCAFE0001; memByteEn = 4'hF; memWe = 1'b1; memRe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    memWe = 1'b0; memRe = 1'b0;
    memRead(6'd12, 4'hF, rd, rq);
    chk("R1 write wins over read", rd, 32'hCAFE0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule